// File: doc/BRIEF.md
# Per-Processor Interrupt Steering and Interval Timer

This block takes a vector of 64 level-sensitive device interrupt lines and steers them to four processors. A registered copy of the lines forms a shared request vector. One extra input, the cascade line from an upstream legacy controller, is ORed into request bit 55. Each processor has its own 64-bit enable mask. A processor's interrupt output is high while any enabled request bit is set.

Each processor also owns a 25-bit interval counter. Software loads the low 24 bits. Every rising edge of a shared periodic tick decrements all counters. When a counter passes below zero, its top bit is set and then stays set. On every tick that leaves the top bit set, that processor receives a one-cycle timer event. A synthesis parameter marks which processors exist. Processors marked absent never receive an interrupt or a timer event, and their counters ignore the tick.

Software reaches the state through a simple request/acknowledge register port. The offsets are kept on a 64-byte stride, because existing drivers decode them.

Top module: `irq_steer_top`

## Requirements
- R1: The request vector equals `irq_lines` sampled at the previous clock edge, with `cascade_irq` ORed into bit 55. It reads back unmasked at offset 0x300.
- R2: For each present processor, `cpu_irq[i]` is the OR of (mask i AND request vector). It follows a change of either one on the same cycle the register changes.
- R3: The mask registers are readable and writable at offsets 0x200 (processor 0), 0x240 (processor 1), 0x600 (processor 2) and 0x640 (processor 3).
- R4: The masked views at 0x280, 0x2C0, 0x680 and 0x6C0 (processors 0 to 3) read mask AND request. Writes to these views and to 0x300 change nothing.
- R5: The interval counters are at 0x380, 0x3C0, 0x700 and 0x740 (processors 0 to 3). A write stores bits 23:0 of the data, and the value then reads with bit 24 equal to 0.
- R6: On each rising edge of `tick`, every present counter becomes ((value − 1) mod 2^25) OR (its old bit 24). A tick held high for several cycles counts once.
- R7: `cpu_timer[i]` pulses high for one cycle after each tick that leaves bit 24 of counter i set.
- R8: A non-aligned offset, an offset not listed here, or an address at or above 0x1000 gives `bus_err` = 1 with its acknowledge. The reserved offsets read as zero, ignore writes and give no error. The reserved offsets are 0x000, 0x040, 0x080, 0x0C0, 0x100, 0x140, 0x180, 0x1C0, 0x340, 0x400, 0x440, 0x480, 0x4C0, 0x580, 0x5C0, 0x780, 0xC00, 0xC40, 0xC80 and 0xCC0.
- R9: The processors present are set by parameter (default 4'b0111, so processor 3 is absent). An absent processor's counter holds its value across ticks, and its `cpu_irq` and `cpu_timer` stay low.
- R10: Every request is acknowledged exactly one cycle later. A counter write on the same cycle as a tick rising edge stores the written value for that counter, and that counter raises no event.
- R11: After reset, the masks, request vector and counters are zero, and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | 64 | Level device interrupt lines |
| cascade_irq | input | 1 | Legacy cascade line, feeds request bit 55 |
| tick | input | 1 | Shared periodic tick, rising edge counts |
| bus_req | input | 1 | Register access request, one cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte offset |
| bus_wdata | input | 64 | Write data |
| bus_ack | output | 1 | Access acknowledge, one cycle after request |
| bus_err | output | 1 | Access error, valid with acknowledge |
| bus_rdata | output | 64 | Read data, valid with acknowledge |
| cpu_irq | output | 4 | Level interrupt per processor |
| cpu_timer | output | 4 | One-cycle timer event per processor |

## Verification
The assertions assume the following about the inputs:
- `bus_req` is a single-cycle pulse.
- `tick` starts low after reset, so the first rising edge comes from the stimulus and not from reset release.
- The interrupt lines are treated as synchronous inputs.

The stimulus drives every input on the falling edge. It pulses the request for one cycle at a time, with a gap between accesses. It keeps `tick` low during reset and raises it only from the tick tasks.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;

    typedef enum logic [2:0] {
        RK_MASK = 3'd0,
        RK_VIEW = 3'd1,
        RK_RAW  = 3'd2,
        RK_CNT  = 3'd3,
        RK_RSVD = 3'd4,
        RK_BAD  = 3'd5
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e  kind;
        logic [1:0] idx;
    } reg_sel_t;

endpackage

// File: rtl/irq_addr_decode.sv
module irq_addr_decode
    import irq_steer_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_t          sel
);

    always_comb begin
        sel.kind = RK_BAD;
        sel.idx  = 2'd0;
        if (addr[ADDR_W-1:12] == '0) begin
            case (addr[11:0])
                12'h200, 12'h240, 12'h600, 12'h640: begin
                    sel.kind = RK_MASK;
                    sel.idx  = {addr[10], addr[6]};
                end
                12'h280, 12'h2C0, 12'h680, 12'h6C0: begin
                    sel.kind = RK_VIEW;
                    sel.idx  = {addr[10], addr[6]};
                end
                12'h300: sel.kind = RK_RAW;
                12'h380: begin sel.kind = RK_CNT; sel.idx = 2'd0; end
                12'h3C0: begin sel.kind = RK_CNT; sel.idx = 2'd1; end
                12'h700: begin sel.kind = RK_CNT; sel.idx = 2'd2; end
                12'h740: begin sel.kind = RK_CNT; sel.idx = 2'd3; end
                12'h000, 12'h040, 12'h080, 12'h0C0,
                12'h100, 12'h140, 12'h180, 12'h1C0,
                12'h340, 12'h400, 12'h440, 12'h480,
                12'h4C0, 12'h580, 12'h5C0, 12'h780,
                12'hC00, 12'hC40, 12'hC80, 12'hCC0: sel.kind = RK_RSVD;
                default: sel.kind = RK_BAD;
            endcase
        end
    end

endmodule

// File: rtl/irq_req_router.sv
module irq_req_router #(
    parameter int              NCPU     = 4,
    parameter int              REQ_W    = 64,
    parameter int              CASC_BIT = 55,
    parameter logic [NCPU-1:0] PRESENT  = '1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [REQ_W-1:0]             lines,
    input  logic                         cascade,
    input  logic [NCPU-1:0]              mask_wr,
    input  logic [REQ_W-1:0]             wdata,
    output logic [REQ_W-1:0]             req_q,
    output logic [NCPU-1:0][REQ_W-1:0]   mask_q,
    output logic [NCPU-1:0]              irq
);

    typedef struct packed {
        logic [REQ_W-1:0]           req;
        logic [NCPU-1:0][REQ_W-1:0] mask;
    } route_t;

    route_t st_d, st_q;

    always_comb begin
        st_d               = st_q;
        st_d.req           = lines;
        st_d.req[CASC_BIT] = lines[CASC_BIT] | cascade;
        for (int i = 0; i < NCPU; i++) begin
            if (mask_wr[i]) begin
                st_d.mask[i] = wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_q  = st_q.req;
    assign mask_q = st_q.mask;

    for (genvar g = 0; g < NCPU; g++) begin : g_cpu
        if (PRESENT[g]) begin : g_on
            assign irq[g] = |(st_q.mask[g] & st_q.req);

            // R2
            irq_change_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !$stable(irq[g]) |-> (!$stable(st_q.req) || !$stable(st_q.mask[g])));
        end else begin : g_off
            assign irq[g] = 1'b0;
        end
    end

    // R1
    cascade_sets_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cascade |=> req_q[CASC_BIT]);

endmodule

// File: rtl/irq_interval_bank.sv
module irq_interval_bank #(
    parameter int              NCPU    = 4,
    parameter int              CNT_W   = 24,
    parameter logic [NCPU-1:0] PRESENT = '1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      tick,
    input  logic [NCPU-1:0]           wr_en,
    input  logic [CNT_W-1:0]          wdata,
    output logic [NCPU-1:0][CNT_W:0]  cnt_q,
    output logic [NCPU-1:0]           evt
);

    localparam int CW = CNT_W + 1;

    typedef struct packed {
        logic                     tick_prev;
        logic [NCPU-1:0]          evt;
        logic [NCPU-1:0][CW-1:0]  cnt;
    } bank_t;

    bank_t st_d, st_q;
    logic  tick_rise;

    always_comb begin
        st_d           = st_q;
        st_d.tick_prev = tick;
        st_d.evt       = '0;
        tick_rise      = tick && !st_q.tick_prev;
        for (int i = 0; i < NCPU; i++) begin
            if (wr_en[i]) begin
                st_d.cnt[i] = {1'b0, wdata};
            end else if (tick_rise && PRESENT[i]) begin
                st_d.cnt[i] = (st_q.cnt[i] - CW'(1))
                            | {st_q.cnt[i][CW-1], {CNT_W{1'b0}}};
                st_d.evt[i] = st_d.cnt[i][CW-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_q = st_q.cnt;
    assign evt   = st_q.evt;

    for (genvar g = 0; g < NCPU; g++) begin : g_chk
        // R5
        write_clears_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en[g] |=> !cnt_q[g][CW-1]);

        // R6
        underflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_q[g][CW-1] && !wr_en[g]) |=> cnt_q[g][CW-1]);

        // R7
        event_needs_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
            evt[g] |-> cnt_q[g][CW-1]);

        if (!PRESENT[g]) begin : g_absent
            // R9
            absent_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !wr_en[g] |=> ($stable(cnt_q[g]) && !evt[g]));
        end
    end

endmodule

// File: rtl/irq_steer_top.sv
module irq_steer_top
    import irq_steer_pkg::*;
#(
    parameter int         REQ_W    = 64,
    parameter int         CASC_BIT = 55,
    parameter int         CNT_W    = 24,
    parameter int         ADDR_W   = 16,
    parameter logic [3:0] PRESENT  = 4'b0111
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REQ_W-1:0]  irq_lines,
    input  logic              cascade_irq,
    input  logic              tick,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REQ_W-1:0]  bus_wdata,
    output logic              bus_ack,
    output logic              bus_err,
    output logic [REQ_W-1:0]  bus_rdata,
    output logic [3:0]        cpu_irq,
    output logic [3:0]        cpu_timer
);

    localparam int NCPU = 4;

    typedef struct packed {
        logic             ack;
        logic             err;
        logic [REQ_W-1:0] rdata;
    } rsp_t;

    reg_sel_t                    sel;
    logic [NCPU-1:0]             mask_wr;
    logic [NCPU-1:0]             cnt_wr;
    logic [REQ_W-1:0]            req_q;
    logic [NCPU-1:0][REQ_W-1:0]  mask_q;
    logic [NCPU-1:0][CNT_W:0]    cnt_q;
    logic [REQ_W-1:0]            rd_val;
    rsp_t                        rsp_d, rsp_q;

    irq_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    for (genvar g = 0; g < NCPU; g++) begin : g_wr
        assign mask_wr[g] = bus_req && bus_we && (sel.kind == RK_MASK) && (sel.idx == g);
        assign cnt_wr[g]  = bus_req && bus_we && (sel.kind == RK_CNT)  && (sel.idx == g);
    end

    irq_req_router #(
        .NCPU     (NCPU),
        .REQ_W    (REQ_W),
        .CASC_BIT (CASC_BIT),
        .PRESENT  (PRESENT)
    ) u_route (
        .clk     (clk),
        .rst_n   (rst_n),
        .lines   (irq_lines),
        .cascade (cascade_irq),
        .mask_wr (mask_wr),
        .wdata   (bus_wdata),
        .req_q   (req_q),
        .mask_q  (mask_q),
        .irq     (cpu_irq)
    );

    irq_interval_bank #(
        .NCPU    (NCPU),
        .CNT_W   (CNT_W),
        .PRESENT (PRESENT)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .wr_en (cnt_wr),
        .wdata (bus_wdata[CNT_W-1:0]),
        .cnt_q (cnt_q),
        .evt   (cpu_timer)
    );

    always_comb begin
        case (sel.kind)
            RK_MASK: rd_val = mask_q[sel.idx];
            RK_VIEW: rd_val = mask_q[sel.idx] & req_q;
            RK_RAW:  rd_val = req_q;
            RK_CNT:  rd_val = REQ_W'(cnt_q[sel.idx]);
            default: rd_val = '0;
        endcase
        rsp_d.ack   = bus_req;
        rsp_d.err   = bus_req && (sel.kind == RK_BAD);
        rsp_d.rdata = (bus_req && !bus_we && sel.kind != RK_BAD) ? rd_val : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign bus_ack   = rsp_q.ack;
    assign bus_err   = rsp_q.err;
    assign bus_rdata = rsp_q.rdata;

    // R10
    ack_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |=> bus_ack);

    // R10
    no_spurious_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_req |=> !bus_ack);

    // R8
    err_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> bus_ack);

endmodule

// File: tb/tb_irq_steer_top.sv
module tb_irq_steer_top;

    localparam logic [3:0] PRES = 4'b0111;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] irq_lines = '0;
    logic        cascade_irq = 1'b0;
    logic        tick = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [63:0] bus_wdata = '0;
    logic        bus_ack, bus_err;
    logic [63:0] bus_rdata;
    logic [3:0]  cpu_irq, cpu_timer;

    irq_steer_top dut (
        .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .cascade_irq(cascade_irq),
        .tick(tick), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_err(bus_err),
        .bus_rdata(bus_rdata), .cpu_irq(cpu_irq), .cpu_timer(cpu_timer)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [63:0] q_data[$];
    logic        q_err[$];
    string       q_tag[$];

    logic [63:0] m_mask[4];
    logic [24:0] m_cnt[4];
    logic [63:0] m_req;

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] mask_addr(input int i);
        case (i) 0: return 16'h200; 1: return 16'h240; 2: return 16'h600; default: return 16'h640; endcase
    endfunction
    function automatic logic [15:0] view_addr(input int i);
        case (i) 0: return 16'h280; 1: return 16'h2C0; 2: return 16'h680; default: return 16'h6C0; endcase
    endfunction
    function automatic logic [15:0] cnt_addr(input int i);
        case (i) 0: return 16'h380; 1: return 16'h3C0; 2: return 16'h700; default: return 16'h740; endcase
    endfunction

    function automatic logic [3:0] exp_irq();
        logic [3:0] r;
        for (int i = 0; i < 4; i++) r[i] = PRES[i] && ((m_mask[i] & m_req) != 0);
        return r;
    endfunction

    // counter model: returns event bit for this cpu
    function automatic logic tick_one(input int i);
        logic top;
        if (!PRES[i]) return 1'b0;
        top = m_cnt[i][24];
        if (m_cnt[i][23:0] == 24'd0) begin
            m_cnt[i][23:0] = 24'hFFFFFF;
            top = 1'b1;
        end else begin
            m_cnt[i][23:0] = m_cnt[i][23:0] - 24'd1;
        end
        m_cnt[i][24] = top;
        return top;
    endfunction

    // monitor: pops expected responses
    always @(negedge clk) begin
        if (rst_n && bus_ack) begin
            if (q_data.size() == 0) begin
                chk(1'b0, "R10 unexpected acknowledge", 64'd1, 64'd0);
            end else begin
                logic [63:0] ed;
                logic        ee;
                string       et;
                ed = q_data.pop_front();
                ee = q_err.pop_front();
                et = q_tag.pop_front();
                chk(bus_err == ee, {et, " err"}, {63'd0, bus_err}, {63'd0, ee});
                chk(bus_rdata == ed, {et, " data"}, bus_rdata, ed);
            end
        end
    end

    task automatic bus_rd(input logic [15:0] a, input logic [63:0] e, input logic er, input string tag);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        q_data.push_back(e); q_err.push_back(er); q_tag.push_back(tag);
        @(negedge clk);
        bus_req = 1'b0;
    endtask

    task automatic bus_wr(input logic [15:0] a, input logic [63:0] d, input logic er, input string tag);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        q_data.push_back(64'd0); q_err.push_back(er); q_tag.push_back(tag);
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic set_lines(input logic [63:0] l, input logic c);
        @(negedge clk);
        irq_lines = l; cascade_irq = c;
        m_req = l; m_req[55] = l[55] | c;
        @(negedge clk);
        chk(cpu_irq == exp_irq(), "R2 cpu_irq after line change", {60'd0, cpu_irq}, {60'd0, exp_irq()});
    endtask

    task automatic do_tick(input int hold);
        logic [3:0] ev;
        @(negedge clk);
        tick = 1'b1;
        for (int i = 0; i < 4; i++) ev[i] = tick_one(i);
        @(negedge clk);
        chk(cpu_timer == ev, "R7 timer event after tick", {60'd0, cpu_timer}, {60'd0, ev});
        for (int k = 1; k < hold; k++) begin
            @(negedge clk);
            chk(cpu_timer == 4'd0, "R6 held tick counts once", {60'd0, cpu_timer}, 64'd0);
        end
        tick = 1'b0;
        @(negedge clk);
        chk(cpu_timer == 4'd0, "R7 event lasts one cycle", {60'd0, cpu_timer}, 64'd0);
    endtask

    task automatic read_counters(input string tag);
        for (int i = 0; i < 4; i++) bus_rd(cnt_addr(i), {39'd0, m_cnt[i]}, 1'b0, tag);
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) begin m_mask[i] = '0; m_cnt[i] = '0; end
        m_req = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        chk(cpu_irq == 4'd0, "R11 cpu_irq reset", {60'd0, cpu_irq}, 64'd0);
        chk(cpu_timer == 4'd0, "R11 cpu_timer reset", {60'd0, cpu_timer}, 64'd0);
        bus_rd(16'h200, 64'd0, 1'b0, "R11 mask0 reset");
        bus_rd(16'h300, 64'd0, 1'b0, "R11 request reset");
        bus_rd(16'h380, 64'd0, 1'b0, "R11 counter0 reset");

        // R3 masks
        m_mask[0] = 64'h1;
        m_mask[1] = 64'h0080_0000_0000_0002;
        m_mask[2] = 64'hFFFF_0000_0000_0000;
        m_mask[3] = '1;
        for (int i = 0; i < 4; i++) bus_wr(mask_addr(i), m_mask[i], 1'b0, "R3 mask write");
        for (int i = 0; i < 4; i++) bus_rd(mask_addr(i), m_mask[i], 1'b0, "R3 mask readback");

        // R1 R2 routing
        set_lines(64'h1, 1'b0);
        bus_rd(16'h300, 64'h1, 1'b0, "R1 raw request");
        set_lines(64'h2, 1'b0);
        set_lines(64'h0, 1'b1);
        bus_rd(16'h300, 64'h0080_0000_0000_0000, 1'b0, "R1 cascade on bit 55");
        set_lines(64'h8000_0000_0000_0003, 1'b1);
        chk(cpu_irq[3] == 1'b0, "R9 absent cpu irq low", {63'd0, cpu_irq[3]}, 64'd0);
        for (int i = 0; i < 4; i++) bus_rd(view_addr(i), m_mask[i] & m_req, 1'b0, "R4 masked view");

        // R4 writes ignored
        bus_wr(16'h280, '1, 1'b0, "R4 view write");
        bus_wr(16'h300, 64'h0, 1'b0, "R4 raw write");
        bus_rd(16'h200, m_mask[0], 1'b0, "R4 mask0 unchanged by view write");
        bus_rd(16'h300, m_req, 1'b0, "R4 raw unchanged by write");

        // R2 mask change alone
        m_mask[0] = 64'h0;
        bus_wr(16'h200, 64'h0, 1'b0, "R2 mask0 clear");
        chk(cpu_irq == exp_irq(), "R2 cpu_irq after mask change", {60'd0, cpu_irq}, {60'd0, exp_irq()});

        // R8 errors and reserved
        bus_rd(16'h208, 64'd0, 1'b1, "R8 misaligned offset");
        bus_rd(16'h1000, 64'd0, 1'b1, "R8 offset above window");
        bus_rd(16'h500, 64'd0, 1'b1, "R8 unlisted offset");
        bus_wr(16'h500, 64'd1, 1'b1, "R8 unlisted write");
        bus_wr(16'h080, '1, 1'b0, "R8 reserved write");
        bus_rd(16'h080, 64'd0, 1'b0, "R8 reserved reads zero");
        bus_rd(16'hC40, 64'd0, 1'b0, "R8 reserved reads zero");

        // R5 counter writes
        m_cnt[0] = 25'd2; m_cnt[1] = 25'hFFFFFF; m_cnt[2] = 25'd0; m_cnt[3] = 25'd5;
        bus_wr(cnt_addr(0), 64'd2, 1'b0, "R5 counter write");
        bus_wr(cnt_addr(1), 64'h1FF_FFFF, 1'b0, "R5 counter write top bit");
        bus_wr(cnt_addr(2), 64'd0, 1'b0, "R5 counter write");
        bus_wr(cnt_addr(3), 64'd5, 1'b0, "R5 counter write");
        read_counters("R5 counter readback");

        // R6 R7 R9 ticks
        do_tick(1);
        do_tick(3);
        read_counters("R6 counters after ticks");
        do_tick(1);
        do_tick(1);
        read_counters("R6 sticky top bit");
        bus_rd(cnt_addr(3), 64'd5, 1'b0, "R9 absent counter holds");

        // R10 write coinciding with tick
        begin
            logic [3:0] ev;
            @(negedge clk);
            bus_req = 1'b1; bus_we = 1'b1; bus_addr = cnt_addr(0); bus_wdata = 64'd7; tick = 1'b1;
            q_data.push_back(64'd0); q_err.push_back(1'b0); q_tag.push_back("R10 write with tick");
            for (int i = 1; i < 4; i++) ev[i] = tick_one(i);
            ev[0] = 1'b0;
            m_cnt[0] = 25'd7;
            @(negedge clk);
            bus_req = 1'b0; bus_we = 1'b0;
            chk(cpu_timer == ev, "R10 write wins over tick event", {60'd0, cpu_timer}, {60'd0, ev});
            tick = 1'b0;
        end
        read_counters("R10 counters after write with tick");

        repeat (3) @(negedge clk);
        chk(q_data.size() == 0, "R10 every request acknowledged", q_data.size(), 64'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule